// File: doc/BRIEF.md
# SPI Register Access Master

This block is the master side of a byte-oriented register protocol for a serial peripheral with a 5-bit register space. A host posts one command at a time: write one register, write a run of (address, value) pairs, read one register, or read a burst of consecutive registers. The block turns the command into one chip-select frame on an SPI link running in mode 1 (clock idles low, the master drives MOSI on the rising edge and samples MISO on the falling edge), most significant bit first, 8-bit words.

Every frame opens with a command byte that carries the register address in its low five bits. Reads then clock out padding. The peripheral needs three bytes of turnaround, so the block drops the first three received bytes and passes the rest to the host as a valid-only stream with a last flag. Burst reads pad with an auto-increment code and end with a plain filler byte. The SCLK half period comes from a divider input. Sequential writes take their pairs from a ready/valid stream. If the stream runs dry the frame pauses with chip select held low.

Top module: `spi_regacc_master`

## Requirements
- R1: Each frame starts with a command byte: bits 7:5 are 3'b100 for a write and 3'b101 for a read, and bits 4:0 are the register address.
- R2: Operation code 2'b00 (single write) sends exactly two bytes in one frame: the write command for cmd_addr, then cmd_wdata.
- R3: Operation code 2'b01 (sequential write) with cmd_len = N sends 2N bytes in one frame. Each pair is taken from the wr stream (wr_addr, wr_data) in order and sent as a write command followed by the data byte. If the stream stalls, SCLK stops and chip select stays low.
- R4: Operation code 2'b10 (single read) sends the read command followed by three 8'hFB bytes. Only the fourth received byte is returned, with rd_last set.
- R5: Operation code 2'b11 (burst read) with cmd_len = N sends N+3 bytes. Byte 0 is the read command, bytes 1 to N+1 are 8'hFC and byte N+2 is 8'hFB. Received bytes 3 to N+2 are returned in order, rd_last marks the final one, and rd_valid occurs only inside the frame.
- R6: SPI mode 1: SCLK idles low, MOSI changes only on a rising SCLK edge, MISO is captured on the falling edge, MSB first.
- R7: Chip select stays low for the whole frame and SCLK is low while it is high. At least one half period passes between chip select falling and the first SCLK edge, and between the last SCLK edge and chip select rising.
- R8: The SCLK half period within a byte is clk_div+1 clock cycles, and no two SCLK edges are closer than that.
- R9: A sequential write or burst read with cmd_len of 0 or above MAX_LEN (default 8) is rejected. The block gives a one-cycle cmd_err pulse and produces no frame.
- R10: After reset, spi_cs_n is high, spi_sclk is low, cmd_ready is high, and busy, rd_valid and cmd_err are low.
- R11: cmd_ready is low for the whole time a frame is in progress (busy high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | DIV_W (8) | SCLK half period minus one, in clk cycles |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle, command accepted when valid |
| cmd_op | input | 2 | 00 single write, 01 sequential write, 10 single read, 11 burst read |
| cmd_addr | input | 5 | Register address for single write and reads |
| cmd_wdata | input | 8 | Data for single write |
| cmd_len | input | LEN_W (4) | Pair count (sequential write) or byte count (burst read) |
| wr_valid | input | 1 | Write pair available |
| wr_ready | output | 1 | Write pair consumed this cycle |
| wr_addr | input | 5 | Register address of the pair |
| wr_data | input | 8 | Data of the pair |
| rd_valid | output | 1 | Read byte valid (one cycle) |
| rd_data | output | 8 | Read byte |
| rd_last | output | 1 | Final byte of the read |
| cmd_err | output | 1 | Command rejected for bad length |
| busy | output | 1 | Frame in progress |
| spi_sclk | output | 1 | SPI clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Master data out |
| spi_miso | input | 1 | Slave data in |

## Verification
The bench targets the burst boundaries. A one-byte burst must still end with 8'hFB after two 8'hFC bytes, and a maximum-length burst must not end early or drop its last byte. An off-by-one in the frame length shows up as a missing or extra byte and a misplaced rd_last. The bench checks that the three turnaround bytes are discarded: a design that counted them would return the command-phase bytes as data. A sequential write is stalled in the middle to check that chip select stays low and the pairs arrive in order. Zero and oversized lengths are sent to check that they never produce a frame. Setup, hold and edge spacing are measured against clk_div, and wrong edge roles show up as corrupted read data.

// File: rtl/spi_regacc_pkg.sv
package spi_regacc_pkg;

  typedef enum logic [1:0] {
    OP_WR_ONE   = 2'b00,
    OP_WR_SEQ   = 2'b01,
    OP_RD_ONE   = 2'b10,
    OP_RD_BURST = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_LOAD  = 3'd2,
    ST_SHIFT = 3'd3,
    ST_HOLD  = 3'd4,
    ST_GAP   = 3'd5
  } seq_st_e;

  localparam logic [2:0] WR_PREFIX  = 3'b100;
  localparam logic [2:0] RD_PREFIX  = 3'b101;
  localparam logic [7:0] PAD_END    = 8'hFB;
  localparam logic [7:0] PAD_STEP   = 8'hFC;
  localparam int         SKIP_BYTES = 3;

endpackage

// File: rtl/spi_regacc_divider.sv
module spi_regacc_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;

  always_comb begin
    tick  = run && (cnt_q == div);
    cnt_d = (!run || tick) ? '0 : cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/spi_regacc_shifter.sv
module spi_regacc_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       load,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx_byte
);

  logic       act_q, act_d;
  logic       phase_q, phase_d;
  logic [2:0] bit_q, bit_d;
  logic [7:0] tx_q, tx_d;
  logic [7:0] rx_q, rx_d;
  logic       sclk_q, sclk_d;
  logic       mosi_q, mosi_d;
  logic       done_q, done_d;
  logic       en;

  always_comb begin
    act_d   = act_q;
    phase_d = phase_q;
    bit_d   = bit_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    sclk_d  = sclk_q;
    mosi_d  = mosi_q;
    done_d  = 1'b0;
    en      = load || (act_q && tick);
    if (load) begin
      act_d   = 1'b1;
      phase_d = 1'b0;
      bit_d   = '0;
      tx_d    = tx_byte;
    end else if (act_q && tick) begin
      if (!phase_q) begin
        // leading edge: rise and launch the next bit
        sclk_d  = 1'b1;
        mosi_d  = tx_q[7];
        phase_d = 1'b1;
      end else begin
        // trailing edge: fall and capture
        sclk_d  = 1'b0;
        rx_d    = {rx_q[6:0], miso};
        tx_d    = {tx_q[6:0], 1'b0};
        phase_d = 1'b0;
        bit_d   = bit_q + 3'd1;
        if (bit_q == 3'd7) begin
          act_d  = 1'b0;
          done_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      phase_q <= 1'b0;
      bit_q   <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      sclk_q  <= 1'b0;
      mosi_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      if (en) begin
        act_q   <= act_d;
        phase_q <= phase_d;
        bit_q   <= bit_d;
        tx_q    <= tx_d;
        rx_q    <= rx_d;
        sclk_q  <= sclk_d;
        mosi_q  <= mosi_d;
      end
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = mosi_q;
  assign done    = done_q;
  assign rx_byte = rx_q;

endmodule

// File: rtl/spi_regacc_seq.sv
module spi_regacc_seq
  import spi_regacc_pkg::*;
#(
  parameter int MAX_LEN = 8,
  parameter int LEN_W   = 4,
  parameter int IDX_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [4:0]       cmd_addr,
  input  logic [7:0]       cmd_wdata,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             wr_valid,
  input  logic [4:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             sh_done,
  input  logic [7:0]       sh_rx,
  output logic             cmd_ready,
  output logic             wr_ready,
  output logic             sh_load,
  output logic [7:0]       sh_tx,
  output logic             cs_n,
  output logic             run,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             rd_last,
  output logic             cmd_err
);

  localparam logic [LEN_W-1:0] LEN_MAX_V = LEN_W'(MAX_LEN);
  localparam logic [IDX_W-1:0] SKIP_V    = IDX_W'(SKIP_BYTES);

  seq_st_e          st_q, st_d;
  op_e              op_q, op_d, op_in;
  logic [4:0]       addr_q, addr_d;
  logic [7:0]       pend_q, pend_d;
  logic [IDX_W-1:0] last_q, last_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             cs_q, cs_d;
  logic             rdv_q, rdv_d;
  logic [7:0]       rdd_q, rdd_d;
  logic             rdl_q, rdl_d;
  logic             err_q, err_d;
  logic             bad_len, first, even, at_end, can_go;
  logic [IDX_W-1:0] last_in;

  always_comb begin
    op_in   = op_e'(cmd_op);
    bad_len = ((op_in == OP_WR_SEQ) || (op_in == OP_RD_BURST)) &&
              ((cmd_len == '0) || (cmd_len > LEN_MAX_V));
    unique case (op_in)
      OP_WR_ONE: last_in = IDX_W'(1);
      OP_WR_SEQ: last_in = IDX_W'({cmd_len, 1'b0}) - IDX_W'(1);
      OP_RD_ONE: last_in = SKIP_V;
      default:   last_in = IDX_W'(cmd_len) + IDX_W'(SKIP_BYTES - 1);
    endcase
  end

  // byte selection for the current frame position
  always_comb begin
    first  = (idx_q == '0);
    even   = !idx_q[0];
    at_end = (idx_q == last_q);
    can_go = 1'b1;
    unique case (op_q)
      OP_WR_ONE: sh_tx = first ? {WR_PREFIX, addr_q} : pend_q;
      OP_WR_SEQ: begin
        sh_tx  = even ? {WR_PREFIX, wr_addr} : pend_q;
        can_go = !even || wr_valid;
      end
      OP_RD_ONE: sh_tx = first ? {RD_PREFIX, addr_q} : PAD_END;
      default:   sh_tx = first ? {RD_PREFIX, addr_q} : (at_end ? PAD_END : PAD_STEP);
    endcase
  end

  always_comb begin
    st_d      = st_q;
    op_d      = op_q;
    addr_d    = addr_q;
    pend_d    = pend_q;
    last_d    = last_q;
    idx_d     = idx_q;
    cs_d      = cs_q;
    rdv_d     = 1'b0;
    rdd_d     = rdd_q;
    rdl_d     = rdl_q;
    err_d     = 1'b0;
    cmd_ready = 1'b0;
    wr_ready  = 1'b0;
    sh_load   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        cmd_ready = 1'b1;
        if (cmd_valid) begin
          if (bad_len) begin
            err_d = 1'b1;
          end else begin
            st_d   = ST_SETUP;
            cs_d   = 1'b0;
            op_d   = op_in;
            addr_d = cmd_addr;
            pend_d = cmd_wdata;
            last_d = last_in;
            idx_d  = '0;
          end
        end
      end
      ST_SETUP: if (tick) st_d = ST_LOAD;
      ST_LOAD: begin
        if (can_go) begin
          sh_load = 1'b1;
          st_d    = ST_SHIFT;
          if ((op_q == OP_WR_SEQ) && even) begin
            wr_ready = 1'b1;
            pend_d   = wr_data;
          end
        end
      end
      ST_SHIFT: begin
        if (sh_done) begin
          if (op_q[1] && (idx_q >= SKIP_V)) begin
            rdv_d = 1'b1;
            rdd_d = sh_rx;
            rdl_d = at_end;
          end
          if (at_end) begin
            st_d = ST_HOLD;
          end else begin
            idx_d = idx_q + IDX_W'(1);
            st_d  = ST_LOAD;
          end
        end
      end
      ST_HOLD: begin
        if (tick) begin
          cs_d = 1'b1;
          st_d = ST_GAP;
        end
      end
      default: if (tick) st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_WR_ONE;
      addr_q <= '0;
      pend_q <= '0;
      last_q <= '0;
      idx_q  <= '0;
      cs_q   <= 1'b1;
      rdv_q  <= 1'b0;
      rdd_q  <= '0;
      rdl_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      addr_q <= addr_d;
      pend_q <= pend_d;
      last_q <= last_d;
      idx_q  <= idx_d;
      cs_q   <= cs_d;
      rdv_q  <= rdv_d;
      rdd_q  <= rdd_d;
      rdl_q  <= rdl_d;
      err_q  <= err_d;
    end
  end

  assign cs_n     = cs_q;
  assign run      = (st_q != ST_IDLE);
  assign rd_valid = rdv_q;
  assign rd_data  = rdd_q;
  assign rd_last  = rdl_q;
  assign cmd_err  = err_q;

endmodule

// File: rtl/spi_regacc_master.sv
module spi_regacc_master #(
  parameter int  MAX_LEN = 8,
  parameter int  DIV_W   = 8,
  localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [4:0]       cmd_addr,
  input  logic [7:0]       cmd_wdata,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [4:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             rd_last,
  output logic             cmd_err,
  output logic             busy,
  output logic             spi_sclk,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso
);

  localparam int IDX_W = $clog2(2 * MAX_LEN + 4);

  logic [1:0] rst_sync;
  logic       rst_int_n;
  logic       tick, run, sh_load, sh_done;
  logic [7:0] sh_tx, sh_rx;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  spi_regacc_divider #(.DIV_W(DIV_W)) u_div (
    .clk  (clk),
    .rst_n(rst_int_n),
    .run  (run),
    .div  (clk_div),
    .tick (tick)
  );

  spi_regacc_shifter u_shift (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick   (tick),
    .load   (sh_load),
    .tx_byte(sh_tx),
    .miso   (spi_miso),
    .sclk   (spi_sclk),
    .mosi   (spi_mosi),
    .done   (sh_done),
    .rx_byte(sh_rx)
  );

  spi_regacc_seq #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tick     (tick),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .cmd_addr (cmd_addr),
    .cmd_wdata(cmd_wdata),
    .cmd_len  (cmd_len),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sh_done  (sh_done),
    .sh_rx    (sh_rx),
    .cmd_ready(cmd_ready),
    .wr_ready (wr_ready),
    .sh_load  (sh_load),
    .sh_tx    (sh_tx),
    .cs_n     (spi_cs_n),
    .run      (run),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rd_last  (rd_last),
    .cmd_err  (cmd_err)
  );

  assign busy = run;

endmodule

// File: rtl/spi_regacc_master_chk.sv
module spi_regacc_master_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] clk_div,
  input logic             spi_sclk,
  input logic             spi_cs_n,
  input logic             spi_mosi,
  input logic             cmd_err,
  input logic             rd_valid
);

  logic           sclk_p, cs_p;
  logic [DIV_W:0] gap;
  logic           evt;

  assign evt = (spi_sclk != sclk_p) || (spi_cs_n != cs_p);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= 1'b0;
      cs_p   <= 1'b1;
      gap    <= '0;
    end else begin
      sclk_p <= spi_sclk;
      cs_p   <= spi_cs_n;
      if (evt)              gap <= '0;
      else if (gap != '1)   gap <= gap + 1'b1;
    end
  end

  // R6
  mosi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_mosi) |-> $rose(spi_sclk));

  // R7
  cs_idle_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  // R8
  half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((spi_sclk != sclk_p) || (spi_cs_n && !cs_p)) |-> (gap >= {1'b0, clk_div}));

  // R9
  err_no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> spi_cs_n);

  // R5
  rd_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !spi_cs_n);

endmodule

bind spi_regacc_master spi_regacc_master_chk #(.DIV_W(DIV_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .clk_div (clk_div),
  .spi_sclk(spi_sclk),
  .spi_cs_n(spi_cs_n),
  .spi_mosi(spi_mosi),
  .cmd_err (cmd_err),
  .rd_valid(rd_valid)
);

// File: tb/spi_regacc_master_tb.sv
module spi_regacc_master_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_LEN    = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] clk_div = 8'd1;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [1:0] cmd_op = 2'b00;
  logic [4:0] cmd_addr = '0;
  logic [7:0] cmd_wdata = '0;
  logic [3:0] cmd_len = '0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_valid, rd_last, cmd_err, busy;
  logic [7:0] rd_data;
  logic       spi_sclk, spi_cs_n, spi_mosi;
  logic       spi_miso = 1'b0;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_regacc_master #(.MAX_LEN(MAX_LEN), .DIV_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_len(cmd_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
    .cmd_err(cmd_err), .busy(busy),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // ---------------- slave model (mode 1) ----------------
  logic [7:0] cap [0:31];
  logic [7:0] sh_in = '0;
  int   byte_cnt = 0;
  int   bit_cnt = 0;
  int   frames = 0;
  int   rises = 0;
  bit   in_frame = 1'b0;
  time  t_csfall, t_rise0, t_rise1, t_lastfall, t_csrise;

  always @(negedge spi_cs_n) begin
    in_frame = 1'b1;
    byte_cnt = 0;
    bit_cnt  = 0;
    rises    = 0;
    t_csfall = $time;
  end

  always @(posedge spi_cs_n) begin
    if (in_frame) begin
      frames++;
      t_csrise = $time;
    end
    in_frame = 1'b0;
  end

  always @(posedge spi_sclk) begin
    if (!spi_cs_n) begin
      logic [7:0] resp;
      if (rises == 0) t_rise0 = $time;
      if (rises == 1) t_rise1 = $time;
      rises++;
      resp = 8'hC0 + 8'(byte_cnt);
      spi_miso = resp[7 - bit_cnt];
    end
  end

  always @(negedge spi_sclk) begin
    if (!spi_cs_n) begin
      sh_in = {sh_in[6:0], spi_mosi};
      bit_cnt++;
      t_lastfall = $time;
      if (bit_cnt == 8) begin
        if (byte_cnt < 32) cap[byte_cnt] = sh_in;
        byte_cnt++;
        bit_cnt = 0;
      end
    end
  end

  // ---------------- read stream / error monitor ----------------
  logic [7:0] rd_buf  [0:15];
  bit         rd_lbuf [0:15];
  int         rd_n  = 0;
  int         err_n = 0;

  always @(negedge clk) begin
    if (rd_valid) begin
      if (rd_n < 16) begin
        rd_buf[rd_n]  = rd_data;
        rd_lbuf[rd_n] = rd_last;
      end
      rd_n++;
    end
    if (cmd_err) err_n++;
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_ge(input string req, input string what, input longint act,
                        input longint lim);
    checks++;
    if (act < lim) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected>=%0d", req, what, act, lim);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [4:0] addr,
                       input logic [7:0] wd, input logic [3:0] len);
    @(negedge clk);
    cmd_op = op; cmd_addr = addr; cmd_wdata = wd; cmd_len = len;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R10", "cs_n after reset", spi_cs_n, 1'b1);
    chk("R10", "sclk after reset", spi_sclk, 1'b0);
    chk("R10", "cmd_ready after reset", cmd_ready, 1'b1);
    chk("R10", "busy after reset", busy, 1'b0);
    chk("R10", "rd_valid after reset", rd_valid, 1'b0);
    chk("R10", "cmd_err after reset", cmd_err, 1'b0);
  endtask

  task automatic t_single_write(input logic [4:0] a, input logic [7:0] d);
    int f0 = frames;
    issue(2'b00, a, d, 4'd0);
    chk("R11", "cmd_ready during frame", cmd_ready, 1'b0);
    wait_idle();
    chk("R2", "single write frames", frames - f0, 1);
    chk("R2", "single write bytes", byte_cnt, 2);
    chk("R1", "write command byte", cap[0], {3'b100, a});
    chk("R2", "write data byte", cap[1], d);
    chk("R6", "sclk idle low", spi_sclk, 1'b0);
  endtask

  task automatic t_seq_write(input int n, input logic [4:0] base);
    int f0 = frames;
    fork
      issue(2'b01, 5'd0, 8'd0, 4'(n));
      begin
        for (int i = 0; i < n; i++) begin
          if (i == 1) repeat (25) @(negedge clk);
          @(negedge clk);
          wr_valid = 1'b1;
          wr_addr  = base + 5'(i);
          wr_data  = 8'h11 * 8'(i + 1);
          #1;
          while (!wr_ready) begin
            @(negedge clk);
            #1;
          end
          @(posedge clk);
          #1;
          wr_valid = 1'b0;
          if (i == 1) chk("R3", "cs held low through stall", spi_cs_n, 1'b0);
        end
      end
    join
    wait_idle();
    chk("R3", "seq write frames", frames - f0, 1);
    chk("R3", "seq write bytes", byte_cnt, 2 * n);
    for (int i = 0; i < n; i++) begin
      chk("R3", "seq write command", cap[2 * i], {3'b100, base + 5'(i)});
      chk("R3", "seq write data", cap[2 * i + 1], 8'h11 * 8'(i + 1));
    end
  endtask

  task automatic t_single_read(input logic [4:0] a);
    int f0 = frames;
    rd_n = 0;
    issue(2'b10, a, 8'h00, 4'd0);
    wait_idle();
    chk("R4", "single read frames", frames - f0, 1);
    chk("R4", "single read bytes", byte_cnt, 4);
    chk("R1", "read command byte", cap[0], {3'b101, a});
    for (int i = 1; i < 4; i++) chk("R4", "filler byte", cap[i], 8'hFB);
    chk("R4", "single read count", rd_n, 1);
    chk("R4", "single read data", rd_buf[0], 8'hC3);
    chk("R4", "single read last", rd_lbuf[0], 1'b1);
  endtask

  task automatic t_burst_read(input int n, input logic [4:0] a);
    int f0 = frames;
    rd_n = 0;
    issue(2'b11, a, 8'h00, 4'(n));
    wait_idle();
    chk("R5", "burst frames", frames - f0, 1);
    chk("R5", "burst bytes", byte_cnt, n + 3);
    chk("R1", "burst command byte", cap[0], {3'b101, a});
    for (int i = 1; i <= n + 1; i++) chk("R5", "increment pad", cap[i], 8'hFC);
    chk("R5", "closing pad", cap[n + 2], 8'hFB);
    chk("R5", "burst data count", rd_n, n);
    for (int k = 0; k < n && k < 16; k++) begin
      chk("R6", "burst data (edge and bit order)", rd_buf[k], 8'hC3 + 8'(k));
      chk("R5", "burst last flag", rd_lbuf[k], (k == n - 1) ? 1'b1 : 1'b0);
    end
  endtask

  task automatic t_bad_len(input logic [1:0] op, input logic [3:0] len);
    int f0 = frames;
    int e0 = err_n;
    issue(op, 5'd3, 8'h00, len);
    repeat (20) @(negedge clk);
    chk("R9", "error pulse count", err_n - e0, 1);
    chk("R9", "no frame on bad length", frames - f0, 0);
    chk("R9", "cs stays high", spi_cs_n, 1'b1);
    chk("R9", "busy stays low", busy, 1'b0);
  endtask

  task automatic t_timing(input logic [7:0] div);
    longint half;
    clk_div = div;
    half = longint'(div + 1) * CLK_PERIOD;
    issue(2'b10, 5'h0A, 8'h00, 4'd0);
    wait_idle();
    chk("R8", "sclk period", longint'(t_rise1 - t_rise0), 2 * half);
    chk_ge("R7", "cs setup", longint'(t_rise0 - t_csfall), half);
    chk_ge("R7", "cs hold", longint'(t_csrise - t_lastfall), half);
    clk_div = 8'd1;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_single_write(5'h00, 8'hA5);
    t_single_write(5'h1F, 8'h3C);
    t_seq_write(3, 5'h1D);
    t_single_read(5'h02);
    t_burst_read(1, 5'h12);
    t_burst_read(5, 5'h14);
    t_burst_read(MAX_LEN, 5'h10);
    t_bad_len(2'b11, 4'd0);
    t_bad_len(2'b01, 4'd0);
    t_bad_len(2'b11, 4'd9);
    t_timing(8'd4);
    t_timing(8'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule